// File: doc/BRIEF.md
# Serial flash command front-end

This block is the device side of the serial link of an SPI-style flash memory. It runs on a fast system clock and oversamples the chip-select, serial clock, data-in and hold pins. Each pin passes through a two-flop synchroniser, and the clock edges are found in the system-clock domain. Incoming bits are assembled into an opcode byte, address bytes and data bytes. Outgoing response bytes are taken from a memory and status model and shifted out on the data-out pin, which has its own output-enable.

When chip select is released, the block decides whether a write-type command is accepted. If it is, the block issues a one-cycle execute strobe carrying the opcode, the address and the number of data bytes. Read-type commands produce no strobe. They may be cut off after any bit.

A hold input can pause a transfer partway through. Hold entry and exit are aligned to the serial clock being low. While the hold lasts, the bit position and the shift registers keep their values.

Top module: `sflash_frontend`

## Requirements
- R1: Every transfer starts with a one-byte opcode. Opcode, address and data bits are captured most significant bit first, on each rising edge of the serial clock from the first rising edge after chip select falls.
- R2: The write-type opcodes give exactly one `exec_valid` pulse after chip select rises, with `exec_op`, `exec_addr` and `exec_count` set, when the byte count is correct. The opcodes and their byte counts are:
  - 0x06 write enable, 0x04 write disable, 0xC7 bulk erase and 0xB9 deep power-down: exactly 1 byte.
  - 0x01 write status: exactly 2 bytes, count 1, address 0.
  - 0xD8 sector erase: exactly 4 bytes, 24-bit address, count 0.
  - 0x02 page program: at least 5 bytes, count equal to the bytes after the address.
- R3: A write-type command whose clock count at chip-select rise is not a multiple of eight produces no `exec_valid`.
- R4: The read-type opcodes drive `do_out` with `do_oe` high, most significant bit first, changing on falling clock edges. The first bit appears on the falling edge that follows the header:
  - 0x03 read data: header of opcode plus 3 address bytes.
  - 0x0B fast read: header of opcode, 3 address bytes and 1 dummy byte.
  - 0xAB release with ID: header of opcode plus 3 dummy bytes.
  - 0x05 read status: header of the opcode only.
  `rd_addr` equals the start address plus the output byte index.
- R5: A read may end at any bit. It then issues no `exec_valid`, turns `do_oe` off, and leaves the next command unaffected.
- R6: Each data byte of 0x02, and the single data byte of 0x01, gives one `wr_valid` pulse carrying `wr_data` and `wr_offset`, counted from 0.
- R7: A hold begins once HOLD is low and the clock is low while selected. If HOLD falls while the clock is high, the hold waits for the clock to fall, and that falling edge is still acted on. During the hold `do_oe` is low, clock and data-in are ignored, and all bit state is kept.
- R8: A hold ends once HOLD is high and the clock is low. A falling edge that ends a hold is itself ignored, and the transfer resumes at the exact bit where it paused.
- R9: A chip-select rise during a hold discards the transfer with no `exec_valid`. A selection that begins while the hold is still in force is ignored entirely.
- R10: An unknown opcode, or a write-type command with the wrong byte count, produces no `exec_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_pin | input | 1 | Chip select pin, active low |
| sck_pin | input | 1 | Serial clock pin |
| di_pin | input | 1 | Serial data-in pin |
| hold_n_pin | input | 1 | Hold pin, active low |
| do_out | output | 1 | Serial data-out value |
| do_oe | output | 1 | Data-out output-enable |
| rd_op | output | 8 | Opcode of the current transfer, for the response model |
| rd_addr | output | ADDR_W | Address of the next response byte |
| rd_byte | input | 8 | Response byte supplied by the model |
| wr_valid | output | 1 | Data byte strobe |
| wr_data | output | 8 | Received data byte |
| wr_offset | output | CNT_W | Index of the data byte within the command |
| exec_valid | output | 1 | Accepted write-type command strobe |
| exec_op | output | 8 | Opcode of the accepted command |
| exec_addr | output | ADDR_W | Address of the accepted command |
| exec_count | output | CNT_W | Data byte count of the accepted command |

## Verification
Each write-type opcode is sent with its exact length. Each is then sent again with a few extra bits, with an extra byte, or with a missing byte, which separates the byte-boundary rule from the length rule. Every read opcode is run through its own header length, including one read that is cut off mid-byte and followed at once by a write-enable. Hold pauses are placed with the clock low and with the clock high. A misaligned entry or exit shifts the data-out stream by one bit, so these pauses detect it. A chip-select rise inside a hold, followed by a selection made while the hold is still in force, checks that both sessions are discarded.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_FAST = 8'h0B;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'hD8;
  localparam logic [7:0] OP_BE   = 8'hC7;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_DP   = 8'hB9;
  localparam logic [7:0] OP_RES  = 8'hAB;

  typedef enum logic [1:0] {CK_NONE, CK_READ, CK_WRITE} cmd_kind_e;

  function automatic cmd_kind_e kind_of(input logic [7:0] op);
    case (op)
      OP_READ, OP_FAST, OP_RDSR, OP_RES:                      return CK_READ;
      OP_PP, OP_SE, OP_BE, OP_WRSR, OP_WREN, OP_WRDI, OP_DP: return CK_WRITE;
      default:                                                return CK_NONE;
    endcase
  endfunction

  // bytes shifted in before the first response bit
  function automatic int unsigned lead_bytes(input logic [7:0] op, input int unsigned abytes);
    case (op)
      OP_READ: return 1 + abytes;
      OP_FAST: return 2 + abytes;
      OP_RES:  return 1 + abytes;
      default: return 1;
    endcase
  endfunction

  function automatic logic has_addr(input logic [7:0] op);
    return (op == OP_READ) || (op == OP_FAST) || (op == OP_PP) || (op == OP_SE);
  endfunction
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[i]}};
      else     chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/sfe_hold.sv
module sfe_hold (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic cs_n_s,
  input  logic sck_s,
  input  logic hold_n_s,
  output logic held
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held <= 1'b0;
    end else if (!held) begin
      // enter only while selected and with the serial clock low
      if (sel && !cs_n_s && !hold_n_s && !sck_s) held <= 1'b1;
    end else if (hold_n_s && (!sck_s || cs_n_s)) begin
      held <= 1'b0;
    end
  end
endmodule

// File: rtl/sfe_serdes.sv
module sfe_serdes #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             ev_rise,
  input  logic             ev_fall,
  input  logic             di,
  input  logic             out_en,
  input  logic [7:0]       tx_byte,
  output logic [2:0]       bit_ph,
  output logic [CNT_W-1:0] byte_cnt,
  output logic             byte_done,
  output logic [7:0]       byte_val,
  output logic [CNT_W-1:0] done_idx,
  output logic [CNT_W-1:0] tx_idx,
  output logic             do_bit,
  output logic             drv
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [6:0] rx_sh;
  logic [6:0] tx_sh;
  logic [2:0] tx_ph;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rx_sh     <= '0;
      bit_ph    <= '0;
      byte_cnt  <= '0;
      byte_done <= 1'b0;
      byte_val  <= '0;
      done_idx  <= '0;
      tx_sh     <= '0;
      tx_ph     <= '0;
      tx_idx    <= '0;
      do_bit    <= 1'b0;
      drv       <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (ev_rise) begin
        rx_sh  <= {rx_sh[5:0], di};
        bit_ph <= bit_ph + 3'd1;
        if (bit_ph == 3'd7) begin
          byte_done <= 1'b1;
          byte_val  <= {rx_sh, di};
          done_idx  <= byte_cnt;
          if (byte_cnt != CNT_TOP) byte_cnt <= byte_cnt + 1'b1;
        end
      end
      if (ev_fall && out_en) begin
        drv <= 1'b1;
        if (tx_ph == 3'd0) begin
          do_bit <= tx_byte[7];
          tx_sh  <= tx_byte[6:0];
        end else begin
          do_bit <= tx_sh[6];
          tx_sh  <= {tx_sh[5:0], 1'b0};
        end
        tx_ph <= tx_ph + 3'd1;
        if (tx_ph == 3'd7 && tx_idx != CNT_TOP) tx_idx <= tx_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sflash_frontend.sv
module sflash_frontend
  import sfe_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_pin,
  input  logic              sck_pin,
  input  logic              di_pin,
  input  logic              hold_n_pin,
  output logic              do_out,
  output logic              do_oe,
  output logic [7:0]        rd_op,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_byte,
  output logic              wr_valid,
  output logic [7:0]        wr_data,
  output logic [CNT_W-1:0]  wr_offset,
  output logic              exec_valid,
  output logic [7:0]        exec_op,
  output logic [ADDR_W-1:0] exec_addr,
  output logic [CNT_W-1:0]  exec_count
);
  localparam int unsigned ADDR_BYTES = ADDR_W / 8;
  localparam logic [CNT_W-1:0] HDR_ADDR = CNT_W'(1 + ADDR_BYTES);

  logic [3:0] pins_s;
  logic cs_n_s, sck_s, di_s, hold_n_s;
  logic cs_q, sck_q, sel, held;
  logic cs_rise, cs_fall, sck_rise, sck_fall, active;

  sfe_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk(clk), .rst(rst),
    .d({hold_n_pin, di_pin, sck_pin, cs_n_pin}),
    .q(pins_s)
  );
  assign cs_n_s   = pins_s[0];
  assign sck_s    = pins_s[1];
  assign di_s     = pins_s[2];
  assign hold_n_s = pins_s[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
      sel   <= 1'b0;
    end else begin
      cs_q  <= cs_n_s;
      sck_q <= sck_s;
      if (cs_rise)      sel <= 1'b0;
      else if (cs_fall) sel <= !held;
    end
  end
  assign cs_rise  = cs_n_s & ~cs_q;
  assign cs_fall  = ~cs_n_s & cs_q;
  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;
  assign active   = sel & ~held;

  sfe_hold u_hold (
    .clk(clk), .rst(rst), .sel(sel), .cs_n_s(cs_n_s),
    .sck_s(sck_s), .hold_n_s(hold_n_s), .held(held)
  );

  logic [2:0]       bit_ph;
  logic [CNT_W-1:0] byte_cnt, done_idx, tx_idx;
  logic             byte_done, drv, out_phase;
  logic [7:0]       byte_val;

  sfe_serdes #(.CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst(rst), .clr(!sel),
    .ev_rise(sck_rise & active), .ev_fall(sck_fall & active),
    .di(di_s), .out_en(out_phase), .tx_byte(rd_byte),
    .bit_ph(bit_ph), .byte_cnt(byte_cnt), .byte_done(byte_done),
    .byte_val(byte_val), .done_idx(done_idx), .tx_idx(tx_idx),
    .do_bit(do_out), .drv(drv)
  );

  assign do_oe = drv & active;

  // command decode as bytes complete
  logic [7:0]        op;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        op_eff;
  assign op_eff = (done_idx == '0) ? byte_val : op;

  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      op        <= '0;
      addr      <= '0;
      out_phase <= 1'b0;
      wr_valid  <= 1'b0;
      wr_data   <= '0;
      wr_offset <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (byte_done) begin
        if (done_idx == '0) op <= byte_val;
        else if (done_idx < HDR_ADDR && has_addr(op)) addr <= {addr[ADDR_W-9:0], byte_val};
        if (op == OP_PP && done_idx >= HDR_ADDR) begin
          wr_valid  <= 1'b1;
          wr_data   <= byte_val;
          wr_offset <= done_idx - HDR_ADDR;
        end
        if (op == OP_WRSR && done_idx == CNT_W'(1)) begin
          wr_valid  <= 1'b1;
          wr_data   <= byte_val;
          wr_offset <= '0;
        end
        if (kind_of(op_eff) == CK_READ &&
            done_idx == CNT_W'(lead_bytes(op_eff, ADDR_BYTES) - 1))
          out_phase <= 1'b1;
      end
    end
  end

  assign rd_op   = op;
  assign rd_addr = addr + ADDR_W'(tx_idx);

  // acceptance of write-type commands at deselect
  logic             len_ok;
  logic [CNT_W-1:0] cnt_out;
  always_comb begin
    len_ok  = 1'b0;
    cnt_out = '0;
    if (bit_ph == 3'd0) begin
      case (op)
        OP_WREN, OP_WRDI, OP_BE, OP_DP: len_ok = (byte_cnt == CNT_W'(1));
        OP_SE:   len_ok = (byte_cnt == HDR_ADDR);
        OP_WRSR: begin
          len_ok  = (byte_cnt == CNT_W'(2));
          cnt_out = CNT_W'(1);
        end
        OP_PP: begin
          len_ok  = (byte_cnt > HDR_ADDR);
          cnt_out = byte_cnt - HDR_ADDR;
        end
        default: len_ok = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exec_valid <= 1'b0;
      exec_op    <= '0;
      exec_addr  <= '0;
      exec_count <= '0;
    end else begin
      exec_valid <= 1'b0;
      if (cs_rise && active && len_ok) begin
        exec_valid <= 1'b1;
        exec_op    <= op;
        exec_addr  <= addr;
        exec_count <= cnt_out;
      end
    end
  end
endmodule

// File: rtl/sfe_checker.sv
module sfe_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             held,
  input logic             sck_s,
  input logic             hold_n_s,
  input logic             cs_n_s,
  input logic             do_oe,
  input logic             exec_valid,
  input logic [7:0]       exec_op,
  input logic [CNT_W-1:0] exec_count,
  input logic [2:0]       bit_ph
);
  assert_oe_off_in_hold_R7: assert property (@(posedge clk) disable iff (rst)
    held |-> !do_oe);
  assert_hold_entry_clk_low_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(held) |-> (!$past(sck_s) && !$past(hold_n_s)));
  assert_hold_exit_pin_high_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(held) |-> $past(hold_n_s));
  assert_exec_after_deselect_R2: assert property (@(posedge clk) disable iff (rst)
    exec_valid |-> cs_n_s);
  assert_exec_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    exec_valid |=> !exec_valid);
  assert_exec_byte_boundary_R3: assert property (@(posedge clk) disable iff (rst)
    exec_valid |-> ($past(bit_ph) == 3'd0));
  assert_no_exec_from_hold_R9: assert property (@(posedge clk) disable iff (rst)
    exec_valid |-> !$past(held));
  assert_oe_only_selected_R5: assert property (@(posedge clk) disable iff (rst)
    do_oe |-> !$past(cs_n_s));
  assert_status_count_R6: assert property (@(posedge clk) disable iff (rst)
    (exec_valid && exec_op == 8'h01) |-> (exec_count == CNT_W'(1)));
endmodule

bind sflash_frontend sfe_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .held(held), .sck_s(sck_s), .hold_n_s(hold_n_s),
  .cs_n_s(cs_n_s), .do_oe(do_oe), .exec_valid(exec_valid), .exec_op(exec_op),
  .exec_count(exec_count), .bit_ph(bit_ph)
);

// File: tb/sflash_frontend_tb.sv
module sflash_frontend_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, di = 1'b0, hold_n = 1'b1;
  logic do_out, do_oe, wr_valid, exec_valid;
  logic [7:0] rd_op, rd_byte, wr_data, exec_op;
  logic [23:0] rd_addr, exec_addr;
  logic [15:0] wr_offset, exec_count;

  always #10 clk = ~clk;

  sflash_frontend u_dut (
    .clk(clk), .rst(rst), .cs_n_pin(cs_n), .sck_pin(sck), .di_pin(di), .hold_n_pin(hold_n),
    .do_out(do_out), .do_oe(do_oe), .rd_op(rd_op), .rd_addr(rd_addr), .rd_byte(rd_byte),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_offset(wr_offset),
    .exec_valid(exec_valid), .exec_op(exec_op), .exec_addr(exec_addr), .exec_count(exec_count)
  );

  function automatic logic [7:0] mem_at(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction
  localparam logic [7:0] STATUS_VAL = 8'h5C;
  localparam logic [7:0] ID_VAL = 8'h13;

  // response model
  assign rd_byte = (rd_op == 8'h05) ? STATUS_VAL : (rd_op == 8'hAB) ? ID_VAL : mem_at(rd_addr);

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  string cur_tag = "R0";

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard queues
  logic [47:0] exec_q[$];
  logic [23:0] wr_q[$];
  int unexp = 0;

  always @(negedge clk) begin
    if (!rst && exec_valid) begin
      if (exec_q.size() == 0) begin
        unexp++;
        chk(1'b0, {cur_tag, " unexpected exec"}, {exec_op, exec_addr, exec_count}, 0);
      end else begin
        logic [47:0] e;
        e = exec_q.pop_front();
        chk({exec_op, exec_addr, exec_count} == e, {cur_tag, " exec"}, {exec_op, exec_addr, exec_count}, e);
      end
    end
    if (!rst && wr_valid) begin
      if (wr_q.size() == 0) begin
        chk(1'b0, {cur_tag, " unexpected wr R6"}, {wr_offset, wr_data}, 0);
      end else begin
        logic [23:0] w;
        w = wr_q.pop_front();
        chk({wr_offset, wr_data} == w, {cur_tag, " wr R6"}, {wr_offset, wr_data}, w);
      end
    end
  end

  task automatic wait_hp();
    repeat (8) @(negedge clk);
  endtask

  task automatic sel_on();
    cs_n = 1'b0;
    wait_hp();
  endtask

  task automatic sel_off();
    wait_hp();
    cs_n = 1'b1;
    repeat (4) wait_hp();
  endtask

  task automatic bit_io(input logic b, output logic so, output logic soe);
    di = b;
    wait_hp();
    so = do_out;
    soe = do_oe;
    sck = 1'b1;
    wait_hp();
    sck = 1'b0;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    logic so, soe;
    for (int i = 0; i < n; i++) bit_io(b[7-i], so, soe);
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_bits(b, 8);
  endtask

  task automatic send_addr(input logic [23:0] a);
    send_byte(a[23:16]);
    send_byte(a[15:8]);
    send_byte(a[7:0]);
  endtask

  // hold taken and released while the clock is low
  task automatic pause_low(input bit in_read);
    hold_n = 1'b0;
    wait_hp();
    wait_hp();
    if (in_read) chk(do_oe == 1'b0, "R7 oe off in hold", do_oe, 0);
    for (int i = 0; i < 2; i++) begin
      di = ~di;
      sck = 1'b1;
      wait_hp();
      sck = 1'b0;
      wait_hp();
    end
    hold_n = 1'b1;
    wait_hp();
  endtask

  // one bit in which hold falls and rises while the clock is high
  task automatic bit_io_pause_high(input logic b, output logic so, output logic soe);
    di = b;
    wait_hp();
    so = do_out;
    soe = do_oe;
    sck = 1'b1;
    wait_hp();
    hold_n = 1'b0;
    wait_hp();
    sck = 1'b0;
    wait_hp();
    wait_hp();
    chk(do_oe == 1'b0, "R7 oe off after delayed entry", do_oe, 0);
    sck = 1'b1;
    di = ~di;
    wait_hp();
    sck = 1'b0;
    wait_hp();
    sck = 1'b1;
    wait_hp();
    hold_n = 1'b1;
    wait_hp();
    sck = 1'b0;
  endtask

  // mode 0 plain, 1 pause with clock high in bit k, 2 pause with clock low after bit k
  task automatic recv_check(input logic [7:0] exp, input int mode, input int k, input string tag);
    logic [7:0] got;
    logic so, soe;
    bit oe_all = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (mode == 1 && i == k) bit_io_pause_high(1'b0, so, soe);
      else bit_io(1'b0, so, soe);
      got[7-i] = so;
      oe_all &= soe;
      if (mode == 2 && i == k) pause_low(1'b1);
    end
    chk(got == exp, tag, got, exp);
    chk(oe_all, {tag, " oe"}, oe_all, 1);
  endtask

  task automatic end_case();
    chk(exec_q.size() == 0 && wr_q.size() == 0 && unexp == 0,
        {cur_tag, " pending or unexpected items"}, exec_q.size() + wr_q.size(), 0);
    unexp = 0;
  endtask

  task automatic exp_exec(input logic [7:0] o, input logic [23:0] a, input logic [15:0] c);
    exec_q.push_back({o, a, c});
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(do_oe == 1'b0 && exec_valid == 1'b0 && wr_valid == 1'b0, "reset state",
        {do_oe, exec_valid, wr_valid}, 0);

    // R1 R2: single-byte write commands
    cur_tag = "R1 R2 wren";
    exp_exec(8'h06, 24'h0, 16'h0);
    sel_on(); send_byte(8'h06); sel_off(); end_case();
    cur_tag = "R2 wrdi";
    exp_exec(8'h04, 24'h0, 16'h0);
    sel_on(); send_byte(8'h04); sel_off(); end_case();
    cur_tag = "R2 bulk erase";
    exp_exec(8'hC7, 24'h0, 16'h0);
    sel_on(); send_byte(8'hC7); sel_off(); end_case();
    cur_tag = "R2 power down";
    exp_exec(8'hB9, 24'h0, 16'h0);
    sel_on(); send_byte(8'hB9); sel_off(); end_case();
    cur_tag = "R1 R2 sector erase";
    exp_exec(8'hD8, 24'hA51E7C, 16'h0);
    sel_on(); send_byte(8'hD8); send_addr(24'hA51E7C); sel_off(); end_case();

    // R6: page program and status write data bytes
    cur_tag = "R2 R6 page program";
    wr_q.push_back({16'd0, 8'h11});
    wr_q.push_back({16'd1, 8'hE2});
    wr_q.push_back({16'd2, 8'h7F});
    exp_exec(8'h02, 24'h000104, 16'd3);
    sel_on(); send_byte(8'h02); send_addr(24'h000104);
    send_byte(8'h11); send_byte(8'hE2); send_byte(8'h7F); sel_off(); end_case();
    cur_tag = "R2 R6 write status";
    wr_q.push_back({16'd0, 8'h9C});
    exp_exec(8'h01, 24'h0, 16'd1);
    sel_on(); send_byte(8'h01); send_byte(8'h9C); sel_off(); end_case();

    // R3: off-boundary deselect
    cur_tag = "R3 wren plus 3 bits";
    sel_on(); send_byte(8'h06); send_bits(8'hFF, 3); sel_off(); end_case();
    cur_tag = "R3 sector erase plus 2 bits";
    sel_on(); send_byte(8'hD8); send_addr(24'h010203); send_bits(8'h00, 2); sel_off(); end_case();
    cur_tag = "R3 opcode cut";
    sel_on(); send_bits(8'hC7, 5); sel_off(); end_case();

    // R10: wrong lengths and unknown opcode
    cur_tag = "R10 wren two bytes";
    sel_on(); send_byte(8'h06); send_byte(8'h00); sel_off(); end_case();
    cur_tag = "R10 program without data";
    sel_on(); send_byte(8'h02); send_addr(24'h000200); sel_off(); end_case();
    cur_tag = "R10 unknown opcode";
    sel_on(); send_byte(8'h9F); send_addr(24'h000000); sel_off(); end_case();

    // R4: read paths
    cur_tag = "R4 read";
    sel_on(); send_byte(8'h03); send_addr(24'h0012FE);
    recv_check(mem_at(24'h0012FE), 0, 0, "R4 read byte0");
    recv_check(mem_at(24'h0012FF), 0, 0, "R4 read byte1");
    recv_check(mem_at(24'h001300), 0, 0, "R4 read byte2");
    sel_off(); end_case();
    chk(do_oe == 1'b0, "R5 oe off after read", do_oe, 0);
    cur_tag = "R4 fast read";
    sel_on(); send_byte(8'h0B); send_addr(24'h3C0040); send_byte(8'hFF);
    recv_check(mem_at(24'h3C0040), 0, 0, "R4 fast byte0");
    recv_check(mem_at(24'h3C0041), 0, 0, "R4 fast byte1");
    sel_off(); end_case();
    cur_tag = "R4 status";
    sel_on(); send_byte(8'h05);
    recv_check(STATUS_VAL, 0, 0, "R4 status byte0");
    recv_check(STATUS_VAL, 0, 0, "R4 status byte1");
    sel_off(); end_case();
    cur_tag = "R4 release id";
    sel_on(); send_byte(8'hAB); send_addr(24'h000000);
    recv_check(ID_VAL, 0, 0, "R4 id byte0");
    sel_off(); end_case();

    // R5: read cut mid-byte, then a write-enable
    cur_tag = "R5 cut read";
    sel_on(); send_byte(8'h03); send_addr(24'h000777); send_bits(8'h00, 3); sel_off();
    chk(do_oe == 1'b0, "R5 oe off after cut", do_oe, 0);
    end_case();
    cur_tag = "R5 command after cut";
    exp_exec(8'h06, 24'h0, 16'h0);
    sel_on(); send_byte(8'h06); sel_off(); end_case();

    // R7 R8: holds during a read
    cur_tag = "R7 R8 read with holds";
    sel_on(); send_byte(8'h03); send_addr(24'h004450);
    recv_check(mem_at(24'h004450), 2, 2, "R7 R8 read low-clock hold");
    recv_check(mem_at(24'h004451), 1, 4, "R7 R8 read high-clock hold");
    recv_check(mem_at(24'h004452), 0, 0, "R8 read after holds");
    sel_off(); end_case();

    // R7 R8: hold inside a page program data byte
    cur_tag = "R7 R8 program with hold";
    wr_q.push_back({16'd0, 8'hB4});
    exp_exec(8'h02, 24'h00AB00, 16'd1);
    sel_on(); send_byte(8'h02); send_addr(24'h00AB00);
    send_bits(8'hB4, 4); pause_low(1'b0);
    send_bits(8'h40, 4);
    sel_off(); end_case();

    // R9: deselect during hold, then a selection under a standing hold
    cur_tag = "R9 deselect in hold";
    sel_on(); send_byte(8'h02); send_addr(24'h002000); send_bits(8'hFF, 3);
    hold_n = 1'b0;
    wait_hp();
    cs_n = 1'b1;
    repeat (4) wait_hp();
    cs_n = 1'b0;
    wait_hp();
    send_byte(8'h06);
    cs_n = 1'b1;
    wait_hp();
    hold_n = 1'b1;
    repeat (4) wait_hp();
    end_case();
    cur_tag = "R9 recovery";
    exp_exec(8'h06, 24'h0, 16'h0);
    sel_on(); send_byte(8'h06); sel_off(); end_case();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R0 actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule